// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave end of a two-wire serial memory of 1024 bytes. It watches the clock and data lines, which arrive already synchronous to the system clock. It finds START, repeated START and STOP conditions and shifts bytes in and out. It holds the array as a behavioural register file. SDA is modelled as an open-drain pull-down: when `sda_oe_o` is high, the line is driven low.

A transfer opens with a select byte. Its top four bits carry a fixed type code. The next bit must equal the `chip_id_i` pin, the next two bits are address bits 9 and 8, and the last bit picks read or write. Reads come in three forms: from the running address counter, from an address loaded by a dummy write, or as a sequential stream. Writes are collected in a slot buffer and are only committed to the array on STOP.

The `burst8_i` pin selects how far a write may run before its address wraps. Tied high, the window is 8 bytes; tied low, it is 16 bytes. Two pins can block a commit: `wr_lock_i` blocks every write, and `top_guard_i` blocks writes to the top quarter of the array. When the block is integrated, an unused `burst8_i` should be tied high and an unused `wr_lock_i` tied low.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_oe_o` is low, every array byte reads 0x00 and the address counter is 0.
- R2: A select byte sent MSB first as 1,0,1,0, chip bit, A9, A8, R/W (1 = read) is acknowledged by holding `sda_oe_o` high through the 9th clock when the chip bit equals `chip_id_i`. Every address and data byte of a write is also acknowledged on its 9th clock.
- R3: A select byte with a wrong type code or a chip bit unequal to `chip_id_i` is not acknowledged. The slave then neither acknowledges nor stores anything until the next START.
- R4: A select byte with R/W=0, an address byte, a repeated START and a select byte with R/W=1 returns the byte at {A9,A8,address}.
- R5: In a read, the 10-bit address counter advances by one after each byte sent, across block boundaries and from 0x3FF to 0x000. The next byte follows while the master acknowledges it (SDA low on the 9th clock).
- R6: When the master does not acknowledge a byte and sends STOP, `sda_oe_o` is low and the counter points at the byte after the last one sent.
- R7: A read with no address byte returns the byte at {A9,A8 of the select byte, low 8 bits of the counter}.
- R8: With `burst8_i` high, each written byte advances only address bits 2..0, so a write wraps inside its aligned 8-byte window and a later byte overwrites an earlier one at the same address.
- R9: With `burst8_i` low, each written byte advances only address bits 3..0, so a write wraps inside its aligned 16-byte window.
- R10: Written bytes reach the array only on STOP; a START that arrives before the STOP discards them.
- R11: If `wr_lock_i` is high at the STOP, the array is left unchanged.
- R12: If `top_guard_i` is high at the STOP and the write falls in 0x300..0x3FF, the array is left unchanged; writes below 0x300 go through.
- R13: A write with one data byte stores that byte with `burst8_i` either high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| chip_id_i | input | 1 | Value the chip bit of the select byte must match |
| burst8_i | input | 1 | 1: 8-byte write window, 0: 16-byte write window |
| wr_lock_i | input | 1 | 1: every write is blocked |
| top_guard_i | input | 1 | 1: writes to 0x300..0x3FF are blocked |
| sda_oe_o | output | 1 | 1: pull the data line low |

## Verification
On the clock edge that completes a data byte, three things happen together. The byte goes into its buffer slot, and the address counter steps with a wrap inside the window the live `burst8_i` pin selects. The bench provokes this by starting writes two or four bytes short of a window's end and running past it, in both window sizes. It judges the result by reading the whole window back through the bus in a scoreboard. The bench also pairs the STOP that commits a write with a high `wr_lock_i` or `top_guard_i` on that same edge. It then reads the target bytes back to see whether the commit was suppressed.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int MEM_DEPTH  = 1024;
    localparam int AW         = $clog2(MEM_DEPTH);
    localparam int WIN_WIDE   = 16;
    localparam int WIN_NARROW = 8;
    localparam int SW         = $clog2(WIN_WIDE);
    localparam int NW         = $clog2(WIN_NARROW);

    localparam logic [3:0] SEL_KIND = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_ADR,
        ST_WDAT,
        ST_ACKW,
        ST_ACKD,
        ST_RDAT,
        ST_RACK,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        logic [3:0] kind;
        logic       chip;
        logic [1:0] blk;
        logic       rd;
    } sel_byte_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    // Advance an address by one while keeping it inside its aligned window.
    function automatic logic [AW-1:0] step_in_window(input logic [AW-1:0] a,
                                                     input logic narrow);
        logic [AW-1:0] mask;
        mask = narrow ? AW'(WIN_NARROW - 1) : AW'(WIN_WIDE - 1);
        return (a & ~mask) | ((a + AW'(1)) & mask);
    endfunction

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
    import eeprom_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_i & scl_q & sda_q & ~sda_i;
        ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'h00;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_wbuf.sv
module eeprom_wbuf #(
    parameter int SLOTS  = 16,
    parameter int AW     = 10,
    localparam int SW     = $clog2(SLOTS),
    localparam int BASE_W = AW - SW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [SW-1:0]     put_slot,
    input  logic [7:0]        put_data,
    input  logic              drop,
    input  logic              go,
    input  logic              allow,
    input  logic [BASE_W-1:0] base_i,
    output logic              busy,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_data
);

    logic [SLOTS-1:0]  vld;
    logic [7:0]        slot_data [SLOTS];
    logic [SW-1:0]     idx;
    logic [BASE_W-1:0] base_q;
    logic              busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            idx    <= '0;
            base_q <= '0;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            idx <= idx + SW'(1);
            if (idx == SW'(SLOTS - 1)) begin
                busy_q <= 1'b0;
                vld    <= '0;
            end
        end else if (go) begin
            if (allow && (|vld)) begin
                busy_q <= 1'b1;
                idx    <= '0;
                base_q <= base_i;
            end else begin
                vld <= '0;
            end
        end else if (drop) begin
            vld <= '0;
        end else if (put) begin
            vld[put_slot] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (put && !busy_q) begin
            slot_data[put_slot] <= put_data;
        end
    end

    assign busy     = busy_q;
    assign mem_we   = busy_q & vld[idx];
    assign mem_addr = {base_q, idx};
    assign mem_data = slot_data[idx];

    // R11
    lock_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !allow && !busy_q) |=> !busy_q);

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic chip_id_i,
    input  logic burst8_i,
    input  logic wr_lock_i,
    input  logic top_guard_i,
    output logic sda_oe_o
);

    localparam int LOW_W = AW - 2;

    bus_ev_t    ev;
    slv_state_e st;
    slv_state_e after_ack;
    logic [2:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       oe_q;
    logic       ack_ok;
    logic       mack;
    logic [AW-1:0] addr_q;

    logic [7:0] byte_in;
    sel_byte_t  sel;
    logic       sel_hit;
    logic       byte_done;
    logic       buf_put;
    logic       commit_allow;
    logic       wb_busy;
    logic       mem_we;
    logic [AW-1:0] mem_waddr;
    logic [7:0] mem_wdata;
    logic [7:0] rd_data;

    i2c_line_mon u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    always_comb begin
        byte_in      = {shreg[6:0], ev.sda};
        sel          = sel_byte_t'(byte_in);
        sel_hit      = (sel.kind == SEL_KIND) && (sel.chip == chip_id_i) && !wb_busy;
        byte_done    = ev.rise && (bit_cnt == 3'd7);
        buf_put      = (st == ST_WDAT) && byte_done;
        commit_allow = !wr_lock_i && !(top_guard_i && (addr_q[AW-1 -: 2] == 2'b11));
    end

    eeprom_wbuf #(
        .SLOTS (WIN_WIDE),
        .AW    (AW)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .put      (buf_put),
        .put_slot (addr_q[SW-1:0]),
        .put_data (byte_in),
        .drop     (ev.start),
        .go       (ev.stop),
        .allow    (commit_allow),
        .base_i   (addr_q[AW-1:SW]),
        .busy     (wb_busy),
        .mem_we   (mem_we),
        .mem_addr (mem_waddr),
        .mem_data (mem_wdata)
    );

    eeprom_array #(
        .DEPTH (MEM_DEPTH),
        .AW    (AW)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_q),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            after_ack <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            tx        <= '0;
            oe_q      <= 1'b0;
            ack_ok    <= 1'b0;
            mack      <= 1'b0;
            addr_q    <= '0;
        end else if (ev.start) begin
            st      <= ST_SEL;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
        end else if (ev.stop) begin
            st   <= ST_IDLE;
            oe_q <= 1'b0;
        end else begin
            unique case (st)
                ST_SEL, ST_ADR, ST_WDAT: begin
                    if (ev.rise) begin
                        shreg   <= byte_in;
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                    if (byte_done) begin
                        st <= ST_ACKW;
                        if (st == ST_SEL) begin
                            ack_ok <= sel_hit;
                            if (sel_hit) begin
                                addr_q[AW-1 -: 2] <= sel.blk;
                            end
                            after_ack <= sel.rd ? ST_RDAT : ST_ADR;
                        end else if (st == ST_ADR) begin
                            addr_q[LOW_W-1:0] <= byte_in;
                            ack_ok            <= 1'b1;
                            after_ack         <= ST_WDAT;
                        end else begin
                            addr_q    <= step_in_window(addr_q, burst8_i);
                            ack_ok    <= 1'b1;
                            after_ack <= ST_WDAT;
                        end
                    end
                end
                ST_ACKW: begin
                    if (ev.fall) begin
                        oe_q <= ack_ok;
                        st   <= ST_ACKD;
                    end
                end
                ST_ACKD: begin
                    if (ev.fall) begin
                        bit_cnt <= '0;
                        if (!ack_ok) begin
                            oe_q <= 1'b0;
                            st   <= ST_SKIP;
                        end else if (after_ack == ST_RDAT) begin
                            tx   <= rd_data;
                            oe_q <= ~rd_data[7];
                            st   <= ST_RDAT;
                        end else begin
                            oe_q <= 1'b0;
                            st   <= after_ack;
                        end
                    end
                end
                ST_RDAT: begin
                    if (ev.fall) begin
                        if (bit_cnt == 3'd7) begin
                            oe_q    <= 1'b0;
                            bit_cnt <= '0;
                            addr_q  <= addr_q + AW'(1);
                            st      <= ST_RACK;
                        end else begin
                            tx      <= {tx[6:0], 1'b0};
                            oe_q    <= ~tx[6];
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.rise) begin
                        mack <= ~ev.sda;
                    end
                    if (ev.fall) begin
                        if (mack) begin
                            tx      <= rd_data;
                            oe_q    <= ~rd_data[7];
                            bit_cnt <= '0;
                            st      <= ST_RDAT;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign sda_oe_o = oe_q;

    // R2
    oe_low_clock_chk: assert property (@(posedge clk) disable iff (rst)
        ((sda_oe_o != $past(sda_oe_o)) && !$past(ev.start | ev.stop)) |-> !$past(scl_i));

    // R3
    skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !sda_oe_o);

    // R8
    narrow_window_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_put && burst8_i) |=> (addr_q[AW-1:NW] == $past(addr_q[AW-1:NW])));

    // R9
    wide_window_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_put && !burst8_i) |=> (addr_q[AW-1:SW] == $past(addr_q[AW-1:SW])));

endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;

    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic chip_id = 1'b0;
    logic burst8 = 1'b1;
    logic wr_lock = 1'b0;
    logic top_guard = 1'b0;
    logic oe;
    logic sda_line;

    assign sda_line = m_sda & ~oe;

    i2c_eeprom_slave u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .chip_id_i   (chip_id),
        .burst8_i    (burst8),
        .wr_lock_i   (wr_lock),
        .top_guard_i (top_guard),
        .sda_oe_o    (oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] wq [$];
    logic [7:0] rd_val;
    event       rd_ev;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q / 2);
        ack = !sda_line;
        tick(Q / 2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_chk(input logic [7:0] b, input bit want, input string tag);
        bit a;
        send_byte(b, a);
        chk(a == want, tag, "acknowledge", int'(a), int'(want));
    endtask

    task automatic read_byte(input bit nack);
        logic [7:0] v;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q / 2);
            v[i] = sda_line;
            tick(Q / 2);
            m_scl = 1'b0;
        end
        tick(Q);
        m_sda = nack; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(1);
        m_sda = 1'b1;
        rd_val = v;
        ->rd_ev;
    endtask

    function automatic logic [7:0] sel_byte(input logic [1:0] blk, input logic rd);
        return {4'b1010, chip_id, blk, rd};
    endfunction

    task automatic write_seq(input logic [9:0] a, input string tag);
        bus_start();
        send_chk(sel_byte(a[9:8], 1'b0), 1'b1, "R2");
        send_chk(a[7:0], 1'b1, "R2");
        foreach (wq[i]) send_chk(wq[i], 1'b1, tag);
        bus_stop();
        tick(40);
    endtask

    task automatic write_one(input logic [9:0] a, input logic [7:0] d, input string tag);
        wq.delete();
        wq.push_back(d);
        write_seq(a, tag);
    endtask

    task automatic rand_read(input logic [9:0] a, input int n);
        bus_start();
        send_chk(sel_byte(a[9:8], 1'b0), 1'b1, "R4");
        send_chk(a[7:0], 1'b1, "R4");
        bus_start();
        send_chk(sel_byte(a[9:8], 1'b1), 1'b1, "R4");
        for (int i = 0; i < n; i++) read_byte(i == n - 1);
        bus_stop();
        tick(10);
    endtask

    task automatic cur_read(input logic [1:0] blk, input int n);
        bus_start();
        send_chk(sel_byte(blk, 1'b1), 1'b1, "R7");
        for (int i = 0; i < n; i++) read_byte(i == n - 1);
        bus_stop();
        tick(10);
    endtask

    // Scoreboard monitor: compares each byte read off the bus with the queue.
    initial begin
        logic [7:0] e;
        string      t;
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected read byte", int'(rd_val), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_val == e, t, "read byte", int'(rd_val), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1: reset state
        chk(oe == 1'b0, "R1", "sda_oe after reset", int'(oe), 0);
        expect_byte(8'h00, "R1");
        cur_read(2'b00, 1);

        // R13: single-byte writes in both window modes
        burst8 = 1'b1;
        write_one(10'h005, 8'hA5, "R13");
        burst8 = 1'b0;
        write_one(10'h006, 8'h5A, "R13");
        burst8 = 1'b1;
        write_one(10'h107, 8'h71, "R13");

        // R4 then R6: NACK + STOP leaves the counter on the next byte
        expect_byte(8'hA5, "R4");
        rand_read(10'h005, 1);
        chk(oe == 1'b0, "R6", "sda_oe after nack and stop", int'(oe), 0);
        expect_byte(8'h5A, "R6");
        cur_read(2'b00, 1);
        // R7: block bits taken from the select byte, low bits from the counter
        expect_byte(8'h71, "R7");
        cur_read(2'b01, 1);

        // R5: sequential read
        expect_byte(8'hA5, "R5");
        expect_byte(8'h5A, "R5");
        rand_read(10'h005, 2);

        // R8: 8-byte window wrap with overwrite
        burst8 = 1'b1;
        wq.delete();
        for (int i = 0; i < 10; i++) wq.push_back(8'h10 + 8'(i));
        write_seq(10'h1F6, "R8");
        for (int i = 0; i < 8; i++) expect_byte(8'h12 + 8'(i), "R8");
        expect_byte(8'h00, "R8");
        rand_read(10'h1F0, 9);

        // R9: 16-byte window wrap
        burst8 = 1'b0;
        wq.delete();
        for (int i = 0; i < 6; i++) wq.push_back(8'h40 + 8'(i));
        write_seq(10'h2FC, "R9");
        expect_byte(8'h44, "R9");
        expect_byte(8'h45, "R9");
        rand_read(10'h2F0, 2);
        for (int i = 0; i < 4; i++) expect_byte(8'h40 + 8'(i), "R9");
        expect_byte(8'h00, "R5");
        rand_read(10'h2FC, 5);
        burst8 = 1'b1;

        // R10: repeated START before STOP discards the buffered byte
        bus_start();
        send_chk(sel_byte(2'b00, 1'b0), 1'b1, "R2");
        send_chk(8'h10, 1'b1, "R2");
        send_chk(8'h77, 1'b1, "R10");
        bus_start();
        send_chk(sel_byte(2'b00, 1'b1), 1'b1, "R10");
        expect_byte(8'h00, "R10");
        read_byte(1'b1);
        bus_stop();
        tick(40);
        expect_byte(8'h00, "R10");
        rand_read(10'h010, 1);

        // R11: write lock
        wr_lock = 1'b1;
        write_one(10'h020, 8'hEE, "R11");
        wr_lock = 1'b0;
        expect_byte(8'h00, "R11");
        rand_read(10'h020, 1);

        // R12: top-quarter guard
        top_guard = 1'b1;
        write_one(10'h3F0, 8'h33, "R12");
        write_one(10'h0F0, 8'h44, "R12");
        top_guard = 1'b0;
        expect_byte(8'h00, "R12");
        rand_read(10'h3F0, 1);
        expect_byte(8'h44, "R12");
        rand_read(10'h0F0, 1);

        // R5: counter wraps from 0x3FF to 0x000
        write_one(10'h3FF, 8'hC3, "R5");
        write_one(10'h000, 8'h3C, "R5");
        expect_byte(8'hC3, "R5");
        expect_byte(8'h3C, "R5");
        rand_read(10'h3FF, 2);

        // R3: mismatched chip bit and wrong type code are ignored
        chip_id = 1'b1;
        bus_start();
        send_chk({4'b1010, 1'b0, 2'b00, 1'b0}, 1'b0, "R3");
        send_chk(8'h30, 1'b0, "R3");
        send_chk(8'h99, 1'b0, "R3");
        bus_stop();
        tick(40);
        expect_byte(8'h00, "R3");
        rand_read(10'h030, 1);
        bus_start();
        send_chk({4'b1011, 1'b1, 2'b00, 1'b0}, 1'b0, "R3");
        send_byte(8'h31, a);
        chk(a == 1'b0, "R3", "byte after wrong type", int'(a), 0);
        bus_stop();
        tick(40);
        // R2: matching chip bit with chip_id high
        write_one(10'h031, 8'h5C, "R2");
        expect_byte(8'h5C, "R2");
        rand_read(10'h031, 1);

        tick(20);
        chk(exp_q.size() == 0, "R4", "all expected reads seen", exp_q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule